// File: doc/BRIEF.md
# GPIO Bank with Power-Management Event Routing

A parameterised bank of general-purpose pins. Software sets each pin to drive a value or to be sampled. Any sampled pin can also be armed to raise one of two power-management events. The first is a high-priority system-management interrupt (SMI). The second is an OS-visible control interrupt (SCI). Each pin picks its own event class, its own trigger style (edge or level) and its own polarity. Every pin value is synchronised through two flops before detection.

The uppermost pins of the bank may also belong to other functions. Each of them has a per-pin ownership bit. When that bit is cleared, the pin's output enable is blocked and the pin raises no events. Software talks to the bank through a flat single-cycle register port. Each register is one bit per pin. The two event outputs are registered, so they never glitch. The reset input is expected to be asynchronously asserted and already synchronised on release.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset every writable register reads 0. Status reads 0, all output enables are low, and smi_o and sci_o are low.
- R2: A pin whose direction bit is 1 (output) and that the bank owns drives gpio_oe_o high, with gpio_out_o equal to its output-value bit. A direction bit of 0 makes the pin an input.
- R3: The input register returns each pin's value two rising edges after it reaches pin_i, whatever the pin's direction. Writes to that register are ignored.
- R4: With trigger bit 0 (edge) and polarity bit 0, a rising edge on an eligible input sets its status bit on the third rising edge after the pin change. The bit stays set after the pin returns low.
- R5: With trigger bit 0 and polarity bit 1, only a falling edge sets status. A rising edge does not.
- R6: Writing 1 to a status bit of an edge-mode pin clears it on that write's edge. Writing 0 leaves it unchanged. A new edge in the same cycle wins over the clear.
- R7: With trigger bit 1 (level), status follows the active level: high for polarity 0, low for polarity 1. It is delayed by three edges like R4. Writing 1 to it has no lasting effect while the level stays active.
- R8: Routing bit 0 sends a pin to smi_o and routing bit 1 sends it to sci_o. Each output is the registered OR of the eligible, set pins routed to it, and it follows status by one rising edge.
- R9: A pin whose enable bit is 0 never sets status and never drives an event.
- R10: A pin configured as an output never sets status and never drives an event.
- R11: The top NSHARED pins are owned by the bank only while their ownership bit is 1 (reset 0). Unowned pins have gpio_oe_o low and raise no events. Lower pins are always owned, and their ownership bits read back as 1.
- R12: Register addresses: 0 direction, 1 output value, 2 input, 3 enable, 4 trigger, 5 polarity, 6 routing, 7 status, 8 ownership. A write takes effect on the rising edge where wr_en_i is high. rdata_o shows the addressed register combinationally, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | NPINS | Write data, one bit per pin |
| rdata_o | output | NPINS | Read data of the addressed register |
| pin_i | input | NPINS | Pin values from the pads |
| gpio_out_o | output | NPINS | Output values to the pads |
| gpio_oe_o | output | NPINS | Output enables to the pads |
| smi_o | output | 1 | System-management interrupt request |
| sci_o | output | 1 | Control interrupt request |

## Verification
A corrupt synchroniser or previous-value flop shows up as a status bit set or missed on the third edge after a pin change. A stuck or wrongly cleared sticky bit shows in the status readback on the very next read. It also shows at smi_o or sci_o one edge later. Eligibility mistakes in direction, enable or ownership show as an event that should not exist. Routing mistakes show as the event leaving on the wrong output. The bench therefore samples both the status register and both event outputs at exact edge counts after each stimulus.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_DIR   = 4'd0;
  localparam logic [AW-1:0] A_OUT   = 4'd1;
  localparam logic [AW-1:0] A_IN    = 4'd2;
  localparam logic [AW-1:0] A_EN    = 4'd3;
  localparam logic [AW-1:0] A_TRIG  = 4'd4;
  localparam logic [AW-1:0] A_POL   = 4'd5;
  localparam logic [AW-1:0] A_ROUTE = 4'd6;
  localparam logic [AW-1:0] A_STAT  = 4'd7;
  localparam logic [AW-1:0] A_OWN   = 4'd8;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS   = 41,
  parameter int unsigned NSHARED = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic [NPINS-1:0] in_sync_i,
  input  logic [NPINS-1:0] stat_i,
  output logic [NPINS-1:0] rdata_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] trig_o,
  output logic [NPINS-1:0] pol_o,
  output logic [NPINS-1:0] route_o,
  output logic [NPINS-1:0] own_o,
  output logic [NPINS-1:0] clr_o
);
  localparam int unsigned NFIXED = NPINS - NSHARED;
  localparam logic [NPINS-1:0] FIXED_MASK = {NPINS{1'b1}} >> NSHARED;

  logic [NPINS-1:0] dir_q, out_q, en_q, trig_q, pol_q, route_q, own_q;
  logic [NPINS-1:0] dir_d, out_d, en_d, trig_d, pol_d, route_d, own_d;

  always_comb begin
    dir_d   = dir_q;
    out_d   = out_q;
    en_d    = en_q;
    trig_d  = trig_q;
    pol_d   = pol_q;
    route_d = route_q;
    own_d   = own_q;
    if (wr_en_i) begin
      unique case (addr_i)
        A_DIR:   dir_d   = wdata_i;
        A_OUT:   out_d   = wdata_i;
        A_EN:    en_d    = wdata_i;
        A_TRIG:  trig_d  = wdata_i;
        A_POL:   pol_d   = wdata_i;
        A_ROUTE: route_d = wdata_i;
        A_OWN:   own_d   = wdata_i & ~FIXED_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      en_q    <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
      route_q <= '0;
      own_q   <= '0;
    end else begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      en_q    <= en_d;
      trig_q  <= trig_d;
      pol_q   <= pol_d;
      route_q <= route_d;
      own_q   <= own_d;
    end
  end

  assign clr_o = (wr_en_i && addr_i == A_STAT) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      A_DIR:   rdata_o = dir_q;
      A_OUT:   rdata_o = out_q;
      A_IN:    rdata_o = in_sync_i;
      A_EN:    rdata_o = en_q;
      A_TRIG:  rdata_o = trig_q;
      A_POL:   rdata_o = pol_q;
      A_ROUTE: rdata_o = route_q;
      A_STAT:  rdata_o = stat_i;
      A_OWN:   rdata_o = own_o;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign en_o    = en_q;
  assign trig_o  = trig_q;
  assign pol_o   = pol_q;
  assign route_o = route_q;
  assign own_o   = own_q | FIXED_MASK;

  // R11: fixed pins are always owned, whatever was written
  a_r11_fixed_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o[NFIXED-1:0] == {NFIXED{1'b1}}));
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic elig_i,
  input  logic level_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, stat_q, stat_d;
  logic active, active_prev, edge_hit;

  assign active      = sync_i ^ pol_i;
  assign active_prev = prev_q ^ pol_i;
  assign edge_hit    = active & ~active_prev;

  always_comb begin
    if (level_i) stat_d = elig_i & active;
    else         stat_d = (elig_i & edge_hit) | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R4: an edge-mode status bit holds unless cleared
  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !level_i && !clr_i) |=> stat_q);
  // R9/R10/R11: an ineligible pin never sets a clear status bit
  a_r9_no_set_when_ineligible: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && !elig_i) |=> !stat_q);
  // R7: level-mode status tracks the active level one edge later
  a_r7_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i && elig_i) |=> (stat_q == $past(sync_i ^ pol_i)));
  // R6: a clear with no edge present empties the bit
  a_r6_clear_wins_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && clr_i && !(elig_i && edge_hit)) |=> !stat_q);
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NPINS   = 41,
  parameter int unsigned NSHARED = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [3:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] gpio_out_o,
  output logic [NPINS-1:0] gpio_oe_o,
  output logic             smi_o,
  output logic             sci_o
);
  logic [NPINS-1:0] in_sync, stat, clr;
  logic [NPINS-1:0] dir, outv, en, trig, pol, route, own;
  logic [NPINS-1:0] elig;
  logic smi_q, sci_q, smi_d, sci_d;

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (in_sync)
  );

  gpio_regfile #(.NPINS(NPINS), .NSHARED(NSHARED)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .in_sync_i (in_sync),
    .stat_i    (stat),
    .rdata_o   (rdata_o),
    .dir_o     (dir),
    .out_o     (outv),
    .en_o      (en),
    .trig_o    (trig),
    .pol_o     (pol),
    .route_o   (route),
    .own_o     (own),
    .clr_o     (clr)
  );

  assign elig = en & ~dir & own;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_evt_detect u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (in_sync[p]),
      .elig_i  (elig[p]),
      .level_i (trig[p]),
      .pol_i   (pol[p]),
      .clr_i   (clr[p]),
      .stat_o  (stat[p])
    );
  end

  always_comb begin
    smi_d = |(stat & elig & ~route);
    sci_d = |(stat & elig & route);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= 1'b0;
      sci_q <= 1'b0;
    end else begin
      smi_q <= smi_d;
      sci_q <= sci_d;
    end
  end

  assign smi_o      = smi_q;
  assign sci_o      = sci_q;
  assign gpio_oe_o  = dir & own;
  assign gpio_out_o = outv;

  // R8: an event output needs a set status bit one edge earlier
  a_r8_smi_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> $past(|stat));
  a_r8_sci_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> $past(|stat));
  // R11: an unowned pin is never driven
  a_r11_unowned_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_oe_o & ~own) == '0);
endmodule

// File: tb/gpio_evt_bank_tb.sv
module gpio_evt_bank_tb_top;
  localparam int NP = 41;
  localparam int NS = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [3:0]    addr;
  logic [NP-1:0] wdata, rdata, pins, gout, goe;
  logic          smi, sci;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_evt_bank #(.NPINS(NP), .NSHARED(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .gpio_out_o(gout), .gpio_oe_o(goe), .smi_o(smi), .sci_o(sci)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NP-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [NP-1:0] bitv(input int i);
    return {{(NP-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic t_reset;
    logic [NP-1:0] d;
    rd(4'd0, d);  check("R1 dir", d, 0);
    rd(4'd3, d);  check("R1 enable", d, 0);
    rd(4'd7, d);  check("R1 status", d, 0);
    check("R1 oe", goe, 0);
    check("R1 smi/sci", {smi, sci}, 0);
    rd(4'd12, d); check("R12 unused addr", d, 0);
  endtask

  task automatic t_direction;
    wr(4'd0, bitv(0) | bitv(1) | bitv(40));
    wr(4'd1, bitv(0));
    check("R2 oe fixed pins", goe[1:0], 2'b11);
    check("R2 out value", gout[1:0], 2'b01);
    check("R11 unowned shared oe", goe[40], 1'b0);
    wr(4'd8, bitv(40));
    check("R11 owned shared oe", goe[40], 1'b1);
  endtask

  task automatic t_readback;
    logic [NP-1:0] d;
    pins[5] = 1'b1; pins[1] = 1'b1;
    tick(1);
    rd(4'd2, d); check("R3 not yet after one edge", d[5], 1'b0);
    tick(1);
    rd(4'd2, d); check("R3 input pin readback", d[5], 1'b1);
    check("R3 output pin readback", d[1], 1'b1);
    wr(4'd2, '0);
    rd(4'd2, d); check("R3 write ignored", d[5], 1'b1);
    pins[1] = 1'b0;
    tick(3);
    rd(4'd8, d); check("R11 fixed ownership reads 1", d[31:0], 32'hFFFF_FFFF);
  endtask

  task automatic t_edge_rise;
    logic [NP-1:0] d;
    wr(4'd3, bitv(3) | bitv(4) | bitv(1) | bitv(7 + 31));
    pins[3] = 1'b1;
    tick(2);
    rd(4'd7, d); check("R4 not set after two edges", d[3], 1'b0);
    tick(1);
    rd(4'd7, d); check("R4 set on third edge", d[3], 1'b1);
    check("R8 smi lags status", smi, 1'b0);
    tick(1);
    check("R8 smi asserted", smi, 1'b1);
    check("R8 sci idle for SMI route", sci, 1'b0);
    pins[3] = 1'b0;
    tick(4);
    rd(4'd7, d); check("R4 sticky after pin low", d[3], 1'b1);
    wr(4'd7, '0);
    rd(4'd7, d); check("R6 write 0 keeps status", d[3], 1'b1);
    wr(4'd7, bitv(3));
    rd(4'd7, d); check("R6 write 1 clears", d[3], 1'b0);
    tick(1);
    check("R6 smi drops after clear", smi, 1'b0);
  endtask

  task automatic t_edge_fall_sci;
    logic [NP-1:0] d;
    wr(4'd5, bitv(4));
    wr(4'd6, bitv(4));
    pins[4] = 1'b1;
    tick(4);
    rd(4'd7, d); check("R5 rising ignored", d[4], 1'b0);
    pins[4] = 1'b0;
    tick(3);
    rd(4'd7, d); check("R5 falling sets", d[4], 1'b1);
    tick(1);
    check("R8 sci asserted", sci, 1'b1);
    check("R8 smi idle for SCI route", smi, 1'b0);
    wr(4'd7, bitv(4));
    tick(1);
    check("R6 sci drops", sci, 1'b0);
  endtask

  task automatic t_level;
    logic [NP-1:0] d;
    pins[6] = 1'b1;
    tick(3);
    wr(4'd4, bitv(6));
    wr(4'd5, bitv(6));
    wr(4'd3, bitv(3) | bitv(4) | bitv(1) | bitv(38) | bitv(6));
    tick(2);
    rd(4'd7, d); check("R7 inactive level no status", d[6], 1'b0);
    pins[6] = 1'b0;
    tick(3);
    rd(4'd7, d); check("R7 active-low level sets", d[6], 1'b1);
    wr(4'd7, bitv(6));
    tick(1);
    rd(4'd7, d); check("R7 W1C no lasting effect", d[6], 1'b1);
    check("R8 smi from level pin", smi, 1'b1);
    pins[6] = 1'b1;
    tick(3);
    rd(4'd7, d); check("R7 status follows release", d[6], 1'b0);
    tick(1);
    check("R7 smi released", smi, 1'b0);
  endtask

  task automatic t_ineligible;
    logic [NP-1:0] d;
    pins[7] = 1'b1;
    pins[1] = 1'b1;
    pins[38] = 1'b1;
    tick(5);
    rd(4'd7, d);
    check("R9 disabled pin", d[7], 1'b0);
    check("R10 output pin", d[1], 1'b0);
    check("R11 unowned shared pin", d[38], 1'b0);
    check("R9 R10 R11 no events", {smi, sci}, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; pins = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_direction();
    t_readback();
    t_edge_rise();
    t_edge_fall_sci();
    t_level();
    t_ineligible();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule